// File: doc/BRIEF.md
# PCI Memory Write Initiator

This block moves entries from a local write queue onto a 32-bit multiplexed PCI address/data bus, acting as bus master. Each queue entry holds a word address, a data word and four active-high byte enables. The block requests the bus, issues Memory Write transactions and pops an entry each time a data phase completes. A static mode input selects one of two tenure policies. In single-phase mode, every entry is its own transaction, and the request stays low across the whole run of queued entries. In burst mode, one linear-order transaction carries up to `MAX_BURST` entries per grant.

The initiator adds no wait states of its own. It tolerates a target that claims late and that holds off TRDY#. A target that never claims causes a master abort, which discards the head entry and pulses an error flag to the local side. A target STOP# ends the transaction early. Entries that were not transferred stay queued and are sent in a later transaction.

Top module: `pcim_wr_master`

## Requirements
- R1: In the address phase (the clock where FRAME# first goes low), C/BE# carries 0111 (Memory Write) and AD carries the head entry's word address shifted left by two, with AD[1:0] = 00.
- R2: IRDY# goes low in the clock right after the address phase. During data phases, AD carries the head entry's data and C/BE#[i] is the inverse of byte enable i.
- R3: A data phase completes on the rising edge where IRDY#, TRDY# and DEVSEL# are all low. `wq_pop_o` is high in that clock and in no clock where a phase is still waiting.
- R4: With `burst_en_i` low, each entry is a single-data-phase transaction with FRAME# high during its data phase. REQ# stays low in the address phase while more than one entry is queued, and is already high in the address phase of the last queued entry.
- R5: With `burst_en_i` high at launch, a single transaction carries min(queued count, `MAX_BURST`) data phases. Later entries' addresses are not used, and REQ# is already high in the address phase.
- R6: In burst mode, FRAME# stays low until the second-to-last data phase completes and is high only in the final data phase. A one-entry burst has FRAME# low only in the address phase.
- R7: In the clock after every clock in which AD is driven, `par_oe_o` is high and PAR equals the XOR of the previous clock's AD[31:0] and C/BE#[3:0].
- R8: If DEVSEL# is still high in the `DEVSEL_TO`-th clock after the address phase, the head entry is popped without transfer. The next clock shows FRAME# high, IRDY# low and `abort_o` high for exactly that clock. DEVSEL# low in that clock is still accepted.
- R9: STOP# with DEVSEL# low ends the transaction, and the entry is popped only if TRDY# is also low. If FRAME# was low, the next clock has FRAME# high with IRDY# low and `abort_o` low. Untransferred entries are sent later in order.
- R10: During reset, REQ#, FRAME# and IRDY# are high, AD and PAR are not driven, and `wq_pop_o` and `abort_o` are low.
- R11: The clock after the final data phase of a transaction, or after the closing clock of an abort or stop, has FRAME# and IRDY# high and AD not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_en_i | input | 1 | Selects burst mode, sampled at launch |
| wq_count_i | input | CNT_W | Number of entries in the write queue |
| wq_waddr_i | input | 30 | Head entry word address |
| wq_data_i | input | 32 | Head entry data |
| wq_be_i | input | 4 | Head entry byte enables, active high |
| wq_pop_o | output | 1 | Head entry consumed this clock |
| abort_o | output | 1 | Master abort flag, one clock |
| req_n_o | output | 1 | Bus request, active low |
| gnt_ni | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | FRAME#, active low |
| irdy_n_o | output | 1 | IRDY#, active low |
| devsel_ni | input | 1 | DEVSEL# from target |
| trdy_ni | input | 1 | TRDY# from target |
| stop_ni | input | 1 | STOP# from target |
| ad_o | output | 32 | Address/data output |
| cbe_n_o | output | 4 | Command/byte-enable output, active low |
| ad_oe_o | output | 1 | Drive enable for AD and C/BE# |
| par_o | output | 1 | Even parity over AD and C/BE# |
| par_oe_o | output | 1 | Drive enable for PAR |

## Verification
The bench builds the block with `MAX_BURST` = 4 and `DEVSEL_TO` = 4, so that a six-entry burst is split across two grants. With these values, a target claiming in the fourth data clock sits exactly at the abort boundary. A queue count of 8 bits leaves room for every batch. Random batches mix both modes, late claims, TRDY# wait states, STOP# with and without data, and unclaimed transactions.

// File: rtl/pcim_pkg.sv
package pcim_pkg;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQW,
    ST_ADDR,
    ST_DATA,
    ST_END,
    ST_TURN
  } pcim_state_e;
endpackage

// File: rtl/pcim_dsel_timer.sv
module pcim_dsel_timer #(
  parameter int DEVSEL_TO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic devsel_ni,
  output logic timeout_o
);
  localparam int TO_W = $clog2(DEVSEL_TO + 1);

  logic [TO_W-1:0] cnt_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (active_i && !seen_q) begin
      if (!devsel_ni) seen_q <= 1'b1;
      else            cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = active_i && !seen_q && devsel_ni && (cnt_q == TO_W'(DEVSEL_TO - 1));

  // R8: the sequencer leaves the data state right after a timeout
  a_r8_leave_after_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !active_i);
endmodule

// File: rtl/pcim_par_gen.sv
module pcim_par_gen #(
  parameter int AD_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [3:0]      cbe_n_i,
  input  logic            oe_i,
  output logic            par_o,
  output logic            par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= ^{ad_i, cbe_n_i};
      par_oe_o <= oe_i;
    end
  end
endmodule

// File: rtl/pcim_seq.sv
module pcim_seq
  import pcim_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_BURST = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_en_i,
  input  logic [CNT_W-1:0] wq_count_i,
  input  logic             gnt_ni,
  input  logic             devsel_ni,
  input  logic             trdy_ni,
  input  logic             stop_ni,
  input  logic             timeout_i,
  output pcim_state_e      state_o,
  output logic             req_n_o,
  output logic             frame_n_o,
  output logic             irdy_n_o,
  output logic             abort_o,
  output logic             pop_o
);
  localparam int LEN_W = $clog2(MAX_BURST + 1);

  pcim_state_e      state_q;
  logic             req_n_q, frame_n_q, irdy_n_q, abort_q, mode_q;
  logic [LEN_W-1:0] rem_q, first_len;
  logic             launch, xfer, stopped;

  always_comb begin
    if (!burst_en_i)                               first_len = LEN_W'(1);
    else if (wq_count_i > CNT_W'(MAX_BURST))       first_len = LEN_W'(MAX_BURST);
    else                                           first_len = LEN_W'(wq_count_i);
  end

  assign launch  = (state_q == ST_REQW || state_q == ST_TURN) && !req_n_q && !gnt_ni
                   && (wq_count_i != '0);
  assign xfer    = (state_q == ST_DATA) && !devsel_ni && !trdy_ni;
  assign stopped = (state_q == ST_DATA) && !devsel_ni && !stop_ni;
  assign pop_o   = xfer || ((state_q == ST_DATA) && timeout_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_n_q   <= 1'b1;
      frame_n_q <= 1'b1;
      irdy_n_q  <= 1'b1;
      abort_q   <= 1'b0;
      mode_q    <= 1'b0;
      rem_q     <= '0;
    end else begin
      abort_q <= 1'b0;
      if (launch) begin
        state_q   <= ST_ADDR;
        frame_n_q <= 1'b0;
        mode_q    <= burst_en_i;
        rem_q     <= first_len;
        // burst: one transaction per tenure; single: keep request until last entry
        if (burst_en_i || wq_count_i == CNT_W'(1)) req_n_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (wq_count_i != '0) begin
              req_n_q <= 1'b0;
              state_q <= ST_REQW;
            end
          end
          ST_REQW: ;
          ST_ADDR: begin
            state_q   <= ST_DATA;
            irdy_n_q  <= 1'b0;
            frame_n_q <= (rem_q == LEN_W'(1));
          end
          ST_DATA: begin
            if (timeout_i) begin
              frame_n_q <= 1'b1;
              abort_q   <= 1'b1;
              state_q   <= ST_END;
            end else if (stopped) begin
              if (!frame_n_q) begin
                frame_n_q <= 1'b1;
                state_q   <= ST_END;
              end else begin
                irdy_n_q <= 1'b1;
                state_q  <= ST_TURN;
              end
            end else if (xfer) begin
              if (frame_n_q) begin
                irdy_n_q <= 1'b1;
                state_q  <= ST_TURN;
              end else begin
                rem_q <= rem_q - 1'b1;
                if (rem_q == LEN_W'(2)) frame_n_q <= 1'b1;
              end
            end
          end
          ST_END: begin
            irdy_n_q <= 1'b1;
            state_q  <= ST_TURN;
          end
          ST_TURN: state_q <= req_n_q ? ST_IDLE : ST_REQW;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o   = state_q;
  assign req_n_o   = req_n_q;
  assign frame_n_o = frame_n_q;
  assign irdy_n_o  = irdy_n_q;
  assign abort_o   = abort_q;

  // R5: a burst tenure gives up the request by its address phase
  a_r5_burst_req_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && mode_q) |-> req_n_q);
  // R6: FRAME# is never lowered again inside a transaction
  a_r6_frame_no_relower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && frame_n_q) |=> (frame_n_q || state_q == ST_ADDR));
endmodule

// File: rtl/pcim_wr_master.sv
module pcim_wr_master
  import pcim_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_BURST = 8,
  parameter int DEVSEL_TO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_en_i,
  input  logic [CNT_W-1:0] wq_count_i,
  input  logic [29:0]      wq_waddr_i,
  input  logic [31:0]      wq_data_i,
  input  logic [3:0]       wq_be_i,
  output logic             wq_pop_o,
  output logic             abort_o,
  output logic             req_n_o,
  input  logic             gnt_ni,
  output logic             frame_n_o,
  output logic             irdy_n_o,
  input  logic             devsel_ni,
  input  logic             trdy_ni,
  input  logic             stop_ni,
  output logic [31:0]      ad_o,
  output logic [3:0]       cbe_n_o,
  output logic             ad_oe_o,
  output logic             par_o,
  output logic             par_oe_o
);
  pcim_state_e state;
  logic        timeout;

  pcim_seq #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .burst_en_i (burst_en_i),
    .wq_count_i (wq_count_i),
    .gnt_ni     (gnt_ni),
    .devsel_ni  (devsel_ni),
    .trdy_ni    (trdy_ni),
    .stop_ni    (stop_ni),
    .timeout_i  (timeout),
    .state_o    (state),
    .req_n_o    (req_n_o),
    .frame_n_o  (frame_n_o),
    .irdy_n_o   (irdy_n_o),
    .abort_o    (abort_o),
    .pop_o      (wq_pop_o)
  );

  pcim_dsel_timer #(.DEVSEL_TO(DEVSEL_TO)) u_dsel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (state == ST_ADDR),
    .active_i  (state == ST_DATA),
    .devsel_ni (devsel_ni),
    .timeout_o (timeout)
  );

  // head entry is driven straight through; the queue advances on pop
  always_comb begin
    ad_oe_o = 1'b0;
    ad_o    = '0;
    cbe_n_o = 4'hF;
    unique case (state)
      ST_ADDR: begin
        ad_oe_o = 1'b1;
        ad_o    = {wq_waddr_i, 2'b00};
        cbe_n_o = CMD_MEM_WR;
      end
      ST_DATA, ST_END: begin
        ad_oe_o = 1'b1;
        ad_o    = wq_data_i;
        cbe_n_o = ~wq_be_i;
      end
      default: ;
    endcase
  end

  pcim_par_gen #(.AD_W(32)) u_par (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ad_i     (ad_o),
    .cbe_n_i  (cbe_n_o),
    .oe_i     (ad_oe_o),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  a_r1_addr_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_n_o) |-> (cbe_n_o == 4'b0111 && ad_o[1:0] == 2'b00));
  a_r2_irdy_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_n_o) |=> !irdy_n_o);
  a_r3_pop_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wq_pop_o |-> (!irdy_n_o && ad_oe_o));
  a_r7_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |=> (par_oe_o && par_o == $past(^{ad_o, cbe_n_o})));
  a_r8_abort_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (frame_n_o && !irdy_n_o));
  a_r11_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irdy_n_o) |-> (!ad_oe_o && $past(frame_n_o)));
endmodule

// File: tb/pcim_wr_master_tb.sv
module pcim_wr_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int MAXB  = 4;
  localparam int DTO   = 4;
  localparam int NEVER = 99;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [29:0] m_addr [64];
  logic [31:0] m_data [64];
  logic [3:0]  m_be   [64];
  int head = 0, tail = 0;

  logic             burst_en = 1'b0;
  logic [CNT_W-1:0] wq_count;
  logic [29:0]      wq_waddr;
  logic [31:0]      wq_data;
  logic [3:0]       wq_be;
  logic gnt_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic wq_pop_o, abort_o, req_n_o, frame_n_o, irdy_n_o, ad_oe_o, par_o, par_oe_o;
  logic [31:0] ad_o;
  logic [3:0]  cbe_n_o;

  assign wq_count = CNT_W'(tail - head);
  assign wq_waddr = m_addr[head[5:0]];
  assign wq_data  = m_data[head[5:0]];
  assign wq_be    = m_be[head[5:0]];

  pcim_wr_master #(.CNT_W(CNT_W), .MAX_BURST(MAXB), .DEVSEL_TO(DTO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .burst_en_i(burst_en), .wq_count_i(wq_count),
    .wq_waddr_i(wq_waddr), .wq_data_i(wq_data), .wq_be_i(wq_be), .wq_pop_o(wq_pop_o),
    .abort_o(abort_o), .req_n_o(req_n_o), .gnt_ni(gnt_n), .frame_n_o(frame_n_o),
    .irdy_n_o(irdy_n_o), .devsel_ni(devsel_n), .trdy_ni(trdy_n), .stop_ni(stop_n),
    .ad_o(ad_o), .cbe_n_o(cbe_n_o), .ad_oe_o(ad_oe_o), .par_o(par_o), .par_oe_o(par_oe_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_par(input logic [31:0] ad, input logic [3:0] cbe);
    return ^{ad, cbe};
  endfunction

  function automatic int exp_phases(input int cnt, input logic burst);
    if (!burst) return 1;
    return (cnt > MAXB) ? MAXB : cnt;
  endfunction

  // target model state
  bit    t_act = 0;
  int    dcyc, beat, exp_len, claim, wcnt, post = 0;
  string post_tag;
  bit    stop_here, stop_trdy, mode_b;
  int    f_claim = -1, f_stop_beat = -1;
  bit    f_stop_trdy = 0;
  bit    p_oe = 0;
  logic [31:0] p_ad;
  logic [3:0]  p_cbe;
  bit    pop_seen;
  int    n_txn = 0, n_abort = 0;

  task automatic plan_stop();
    if (f_stop_beat == beat) begin
      stop_here = 1; stop_trdy = f_stop_trdy; f_stop_beat = -1;
    end else begin
      stop_here = ($urandom % 24 == 0);
      stop_trdy = $urandom % 2;
    end
  endtask

  initial begin : monitor
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (p_oe) chk(par_oe_o && par_o == exp_par(p_ad, p_cbe), "R7",
                    {par_oe_o, par_o}, {1'b1, exp_par(p_ad, p_cbe)});
      p_oe = ad_oe_o; p_ad = ad_o; p_cbe = cbe_n_o;
      gnt_n = req_n_o;

      if (post == 1) begin
        chk(frame_n_o && irdy_n_o && !ad_oe_o, "R11", {frame_n_o, irdy_n_o, ad_oe_o}, 3'b110);
        post = 0;
      end else if (post == 2) begin
        chk(frame_n_o && !irdy_n_o && (abort_o == (post_tag == "R8")), post_tag,
            {frame_n_o, irdy_n_o, abort_o}, {2'b10, post_tag == "R8"});
        if (abort_o) n_abort++;
        post = 1;
      end else begin
        chk(!abort_o, "R8", abort_o, 0);
      end

      devsel_n = 1; trdy_n = 1; stop_n = 1;
      if (!t_act) begin
        if (!frame_n_o && irdy_n_o && ad_oe_o) begin
          int cnt;
          cnt = tail - head;
          chk(cbe_n_o == 4'b0111 && ad_o == {m_addr[head[5:0]], 2'b00}, "R1",
              {cbe_n_o, ad_o}, {4'b0111, m_addr[head[5:0]], 2'b00});
          mode_b = burst_en;
          chk(req_n_o == (mode_b ? 1'b1 : (cnt == 1)), mode_b ? "R5" : "R4",
              req_n_o, mode_b ? 1 : (cnt == 1));
          exp_len = exp_phases(cnt, mode_b);
          t_act = 1; dcyc = 0; beat = 0; n_txn++;
          if (f_claim >= 0) begin claim = f_claim; f_claim = -1; end
          else claim = ($urandom % 20 == 0) ? NEVER : int'($urandom % 4);
          wcnt = $urandom % 3;
          plan_stop();
        end
      end else begin
        dcyc++;
        if (dcyc == 1) chk(!irdy_n_o, "R2", irdy_n_o, 0);
        if (dcyc > claim) devsel_n = 0;
        if (!devsel_n) begin
          if (wcnt > 0) wcnt--;
          else begin
            trdy_n = 0;
            if (stop_here) begin stop_n = 0; trdy_n = !stop_trdy; end
          end
        end
      end

      #1;
      if (t_act && dcyc > 0) begin
        if (!devsel_n && !stop_n) begin
          if (!trdy_n) chk(wq_pop_o && ad_o == m_data[head[5:0]], "R9", {wq_pop_o, ad_o},
                           {1'b1, m_data[head[5:0]]});
          else chk(!wq_pop_o, "R9", wq_pop_o, 0);
          post = frame_n_o ? 1 : 2; post_tag = "R9"; t_act = 0;
        end else if (!devsel_n && !trdy_n) begin
          chk(ad_o == m_data[head[5:0]] && cbe_n_o == ~m_be[head[5:0]], "R2",
              {cbe_n_o, ad_o}, {~m_be[head[5:0]], m_data[head[5:0]]});
          chk(wq_pop_o, "R3", wq_pop_o, 1);
          chk(frame_n_o == (beat == exp_len - 1), mode_b ? "R6" : "R4", frame_n_o, beat == exp_len - 1);
          beat++;
          wcnt = $urandom % 3;
          if (frame_n_o) begin
            chk(beat == exp_len, "R5", beat, exp_len);
            t_act = 0; post = 1;
          end else plan_stop();
        end else if (claim == NEVER && dcyc == DTO) begin
          chk(wq_pop_o, "R8", wq_pop_o, 1);
          post = 2; post_tag = "R8"; t_act = 0;
        end else begin
          chk(!wq_pop_o, "R3", wq_pop_o, 0);
        end
      end
      pop_seen = wq_pop_o;
      @(posedge clk);
      #1;
      if (pop_seen) head++;
    end
  end

  task automatic run_round(input int n, input bit b);
    @(posedge clk); #2;
    burst_en = b;
    for (int i = 0; i < n; i++) begin
      m_addr[tail[5:0]] = 30'($urandom);
      m_data[tail[5:0]] = $urandom;
      m_be[tail[5:0]]   = 4'($urandom);
      tail++;
    end
    do @(posedge clk); while (!(head == tail && !t_act && post == 0));
    repeat (3) @(posedge clk);
  endtask

  initial begin : ctrl
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk(req_n_o && frame_n_o && irdy_n_o && !ad_oe_o && !par_oe_o && !wq_pop_o && !abort_o,
        "R10", {req_n_o, frame_n_o, irdy_n_o, ad_oe_o, par_oe_o, wq_pop_o, abort_o}, 7'b1110000);
    @(negedge clk) rst_n = 1'b1;

    run_round(1, 0);
    run_round(3, 0);
    run_round(1, 1);                         // R6 single-entry burst
    run_round(6, 1);                         // R5 cap at MAXB
    f_claim = 3; run_round(2, 1);            // R8 boundary: claim in last allowed clock
    f_claim = NEVER; run_round(2, 0);        // R8 abort, single-phase
    f_claim = NEVER; run_round(3, 1);        // R8 abort inside burst
    f_stop_beat = 1; f_stop_trdy = 1; run_round(4, 1);  // R9 disconnect with data
    f_stop_beat = 0; f_stop_trdy = 0; run_round(2, 0);  // R9 retry
    for (int r = 0; r < 60; r++) run_round(1 + int'($urandom % 6), $urandom % 2);

    chk(n_abort >= 2, "R8", n_abort, 2);
    chk(head == tail, "R3", head, tail);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule